// File: doc/BRIEF.md
# Redundant Pair Recovery Controller

This block is the hardware error handler for two cores that run the same thread side by side. Each core has its own local detectors: single-bit parity on the L1 cache, the register file and the queues, and a mismatch check on its duplicated PC and pipeline registers. Each detector raises a pulse straight into this controller. The controller never compares data between the two cores. A pulse on any source of one core marks that core as faulty and the other as healthy.

Recovery always moves forward. The controller first stops both cores and all L1-to-L2 writeback traffic, and it waits for that stop to be acknowledged. It then copies three things from the healthy core to the faulty one, one after another: the healthy core's communication-buffer section, its register file, and its PC. The register file and PC travel through the shared L2. Each copy has a request and done handshake. When the PC copy is done, the controller releases both cores together. Both resume from the healthy core's PC, so only the faulty core can run instructions a second time.

Some faults cannot be recovered. These are errors on both cores in the same cycle, and any error from the healthy core while a recovery is under way, such as a parity hit in its register file during the copy. In these cases the controller enters a fatal state. It holds both cores stopped and keeps the fatal flag raised until reset.

Top module: `rpr_ctrl`

## Requirements
- R1: After reset, halt, all three copy requests, resume, busy and fatal are 0.
- R2: When the controller is idle and one or more bits of exactly one core's error vector are set, halt and busy are 1 on the next cycle. copy_from_b then gives the healthy source: it is 1 when core A raised the error and 0 when core B raised it.
- R3: No copy request is raised until halt_ack has been sampled high in the halt state. While halt_ack stays low, halt stays 1 and all copy requests stay 0. A copy request is only ever raised while halt is 1.
- R4: Copies run in a fixed order: buffer, then registers, then PC. Each request stays high until its own done input is sampled high, and the next request rises on the following cycle. A done input whose request is low is ignored.
- R5: The cycle after pc_done is sampled with the PC request high, resume is 1 for exactly one cycle with halt at 0. On the cycle after that, busy is 0.
- R6: Error pulses from the faulty core during a recovery are ignored. The active request, the copy direction and fatal are unchanged.
- R7: If both cores raise an error in the same cycle while the controller is idle, fatal is 1 on the next cycle.
- R8: Any error pulse from the healthy core during a recovery sets fatal on the next cycle. This applies from the halt state through the resume cycle. Fatal then stays 1, with halt 1 and no request or resume, until reset, whatever the other inputs do.
- R9: At most one of buffer request, register request, PC request, resume and fatal is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_a | input | NSRC | Core A detector pulses (one bit per local detector) |
| err_b | input | NSRC | Core B detector pulses |
| halt_ack | input | 1 | Both cores and writeback traffic have stopped |
| buf_done | input | 1 | Buffer-section copy finished |
| regs_done | input | 1 | Register-file copy finished |
| pc_done | input | 1 | PC copy finished |
| halt_o | output | 1 | Stop both cores and L1-to-L2 traffic |
| buf_copy_req | output | 1 | Copy the healthy core's buffer section over the faulty one |
| regs_copy_req | output | 1 | Copy the healthy register file through L2 |
| pc_copy_req | output | 1 | Copy the healthy PC through L2 |
| copy_from_b | output | 1 | Copy source / resume PC owner: 1 = core B, 0 = core A |
| resume | output | 1 | One-cycle release of both cores |
| busy | output | 1 | Recovery or fatal in progress |
| fatal | output | 1 | Unrecoverable error, sticky until reset |

## Verification
A wrong internal state shows up at the ports within one cycle of the input that should have moved the sequencer. It appears as a request raised out of order, a handshake that fails to advance, a wrong copy_from_b, or a fatal flag that rises or falls when it should not. The sweep drives every detector bit of each core through a full recovery, with stall lengths that vary. It injects faulty-core pulses that must change nothing and healthy-core pulses at every stage, which must latch fatal. It also injects every pairing of simultaneous errors. The outputs are compared in the cycle each register transition lands.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HALT   = 3'd1,
    ST_CBUF   = 3'd2,
    ST_CREG   = 3'd3,
    ST_CPC    = 3'd4,
    ST_RESUME = 3'd5,
    ST_FATAL  = 3'd6
  } rpr_state_e;
endpackage

// File: rtl/rpr_rst_sync.sv
module rpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rpr_err_merge.sv
module rpr_err_merge #(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0] err_vec,
  output logic            any_err
);
  assign any_err = |err_vec;
endmodule

// File: rtl/rpr_fsm.sv
module rpr_fsm
  import rpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_a,
  input  logic       any_b,
  input  logic       halt_ack,
  input  logic       buf_done,
  input  logic       regs_done,
  input  logic       pc_done,
  output rpr_state_e state_o,
  output logic       src_b_o
);
  rpr_state_e state_q, state_d;
  logic       src_q, src_d, src_en;
  logic       healthy_err;

  assign healthy_err = src_q ? any_b : any_a;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    src_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_a && any_b) begin
          state_d = ST_FATAL;
        end else if (any_a || any_b) begin
          state_d = ST_HALT;
          src_en  = 1'b1;
          src_d   = any_a;
        end
      end
      ST_HALT: begin
        if (healthy_err)   state_d = ST_FATAL;
        else if (halt_ack) state_d = ST_CBUF;
      end
      ST_CBUF: begin
        if (healthy_err)   state_d = ST_FATAL;
        else if (buf_done) state_d = ST_CREG;
      end
      ST_CREG: begin
        if (healthy_err)    state_d = ST_FATAL;
        else if (regs_done) state_d = ST_CPC;
      end
      ST_CPC: begin
        if (healthy_err)  state_d = ST_FATAL;
        else if (pc_done) state_d = ST_RESUME;
      end
      ST_RESUME: begin
        if (healthy_err) state_d = ST_FATAL;
        else             state_d = ST_IDLE;
      end
      ST_FATAL: state_d = ST_FATAL;
      default:  state_d = ST_FATAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= 1'b0;
    else if (src_en) src_q <= src_d;
  end

  assign state_o = state_q;
  assign src_b_o = src_q;
endmodule

// File: rtl/rpr_ctrl.sv
module rpr_ctrl
  import rpr_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] err_a,
  input  logic [NSRC-1:0] err_b,
  input  logic            halt_ack,
  input  logic            buf_done,
  input  logic            regs_done,
  input  logic            pc_done,
  output logic            halt_o,
  output logic            buf_copy_req,
  output logic            regs_copy_req,
  output logic            pc_copy_req,
  output logic            copy_from_b,
  output logic            resume,
  output logic            busy,
  output logic            fatal
);
  localparam int NCORE = 2;

  logic                  rst_sync_n;
  logic [NSRC-1:0]       err_vec [NCORE];
  logic [NCORE-1:0]      core_err;
  rpr_state_e            state;

  assign err_vec[0] = err_a;
  assign err_vec[1] = err_b;

  rpr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_merge
    rpr_err_merge #(.NSRC(NSRC)) u_merge (
      .err_vec (err_vec[c]),
      .any_err (core_err[c])
    );
  end

  rpr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .any_a     (core_err[0]),
    .any_b     (core_err[1]),
    .halt_ack  (halt_ack),
    .buf_done  (buf_done),
    .regs_done (regs_done),
    .pc_done   (pc_done),
    .state_o   (state),
    .src_b_o   (copy_from_b)
  );

  always_comb begin
    halt_o        = 1'b0;
    buf_copy_req  = 1'b0;
    regs_copy_req = 1'b0;
    pc_copy_req   = 1'b0;
    resume        = 1'b0;
    fatal         = 1'b0;
    busy          = (state != ST_IDLE);
    unique case (state)
      ST_HALT:   halt_o = 1'b1;
      ST_CBUF:   begin halt_o = 1'b1; buf_copy_req  = 1'b1; end
      ST_CREG:   begin halt_o = 1'b1; regs_copy_req = 1'b1; end
      ST_CPC:    begin halt_o = 1'b1; pc_copy_req   = 1'b1; end
      ST_RESUME: resume = 1'b1;
      ST_FATAL:  begin halt_o = 1'b1; fatal = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/rpr_ctrl_chk.sv
module rpr_ctrl_chk #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] err_a,
  input logic [NSRC-1:0] err_b,
  input logic            halt_ack,
  input logic            buf_done,
  input logic            regs_done,
  input logic            pc_done,
  input logic            halt_o,
  input logic            buf_copy_req,
  input logic            regs_copy_req,
  input logic            pc_copy_req,
  input logic            copy_from_b,
  input logic            resume,
  input logic            busy,
  input logic            fatal
);
  logic healthy_err;
  assign healthy_err = copy_from_b ? (|err_b) : (|err_a);

  assert_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|err_a) && !(|err_b)) |=> (halt_o && copy_from_b));

  assert_req_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_copy_req || regs_copy_req || pc_copy_req) |-> halt_o);

  assert_ack_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && busy && !fatal && !buf_copy_req && !regs_copy_req && !pc_copy_req && !halt_ack)
      |=> !buf_copy_req);

  assert_hold_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_copy_req && !buf_done && !healthy_err) |=> buf_copy_req);

  assert_order_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(buf_copy_req) && !fatal) |-> regs_copy_req);

  assert_order_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(regs_copy_req) && !fatal) |-> pc_copy_req);

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pc_copy_req) && !fatal) |-> (resume && !halt_o));

  assert_resume_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  assert_src_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !resume && !fatal) |=> $stable(copy_from_b));

  assert_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|err_a) && (|err_b)) |=> fatal);

  assert_healthy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fatal && healthy_err) |=> fatal);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && halt_o));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_copy_req, regs_copy_req, pc_copy_req, resume, fatal}));
endmodule

bind rpr_ctrl rpr_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .err_a         (err_a),
  .err_b         (err_b),
  .halt_ack      (halt_ack),
  .buf_done      (buf_done),
  .regs_done     (regs_done),
  .pc_done       (pc_done),
  .halt_o        (halt_o),
  .buf_copy_req  (buf_copy_req),
  .regs_copy_req (regs_copy_req),
  .pc_copy_req   (pc_copy_req),
  .copy_from_b   (copy_from_b),
  .resume        (resume),
  .busy          (busy),
  .fatal         (fatal)
);

// File: tb/rpr_ctrl_test.sv
module rpr_ctrl_test;
  localparam int NSRC = 5;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] err_a, err_b;
  logic            halt_ack, buf_done, regs_done, pc_done;
  logic            halt_o, buf_copy_req, regs_copy_req, pc_copy_req;
  logic            copy_from_b, resume, busy, fatal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  rpr_ctrl #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .err_a(err_a), .err_b(err_b),
    .halt_ack(halt_ack), .buf_done(buf_done), .regs_done(regs_done), .pc_done(pc_done),
    .halt_o(halt_o), .buf_copy_req(buf_copy_req), .regs_copy_req(regs_copy_req),
    .pc_copy_req(pc_copy_req), .copy_from_b(copy_from_b), .resume(resume),
    .busy(busy), .fatal(fatal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return {29'd0, pc_copy_req, regs_copy_req, buf_copy_req};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    err_a = '0; err_b = '0;
    halt_ack = 0; buf_done = 0; regs_done = 0; pc_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_err(input int core, input int bitn);
    if (core == 0) err_a = NSRC'(1) << bitn;
    else           err_b = NSRC'(1) << bitn;
  endtask

  // inject an error from the healthy core, then confirm the fatal lock
  task automatic healthy_abort(input int healthy, input int bitn, input string stage);
    set_err(healthy, bitn);
    @(negedge clk);
    err_a = '0; err_b = '0;
    chk({"R8 fatal after healthy error at ", stage}, fatal, 1);
    chk("R8 halt held in fatal", halt_o, 1);
    chk("R8 no requests in fatal", reqs(), 0);
    halt_ack = 1; buf_done = 1; regs_done = 1; pc_done = 1;
    set_err(1 - healthy, bitn);
    repeat (3) @(negedge clk);
    halt_ack = 0; buf_done = 0; regs_done = 0; pc_done = 0;
    err_a = '0; err_b = '0;
    chk("R8 fatal sticky", fatal, 1);
    chk("R8 resume low in fatal", resume, 0);
    chk("R9 no requests in fatal", reqs(), 0);
    do_reset();
  endtask

  // abort: 0 halt, 1 buf, 2 regs, 3 pc, 4 resume, 5 none
  task automatic do_rec(input int faulty, input int bitn, input int lat, input int abort);
    int healthy = 1 - faulty;
    set_err(faulty, bitn);
    @(negedge clk);
    err_a = '0; err_b = '0;
    chk("R2 halt after error", halt_o, 1);
    chk("R2 busy after error", busy, 1);
    chk("R2 copy source", copy_from_b, (faulty == 0) ? 1 : 0);
    chk("R3 no request before ack", reqs(), 0);
    if (abort == 0) begin healthy_abort(healthy, bitn, "halt"); return; end
    for (int w = 0; w < lat; w++) begin
      @(negedge clk);
      chk("R3 waiting for ack, no request", reqs(), 0);
      chk("R3 halt held while waiting", halt_o, 1);
    end
    buf_done = 1; regs_done = 1; pc_done = 1;  // stray dones ignored (R4)
    halt_ack = 1;
    @(negedge clk);
    halt_ack = 0; buf_done = 0; regs_done = 0; pc_done = 0;
    chk("R4 buffer request after ack", reqs(), 1);
    for (int k = 0; k < 3; k++) begin
      if (abort == k + 1) begin healthy_abort(healthy, bitn, "copy"); return; end
      set_err(faulty, (bitn + k) % NSRC);
      @(negedge clk);
      err_a = '0; err_b = '0;
      chk("R6 faulty error ignored, request kept", reqs(), 1 << k);
      chk("R6 faulty error ignored, no fatal", fatal, 0);
      chk("R6 faulty error ignored, source kept", copy_from_b, (faulty == 0) ? 1 : 0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk("R4 request held until done", reqs(), 1 << k);
        chk("R9 no resume during copy", resume, 0);
      end
      case (k)
        0: begin buf_done = 1; regs_done = 1; end
        1: begin regs_done = 1; pc_done = 1; end
        default: pc_done = 1;
      endcase
      @(negedge clk);
      buf_done = 0; regs_done = 0; pc_done = 0;
      if (k < 2) chk("R4 next request in order", reqs(), 1 << (k + 1));
    end
    chk("R5 resume pulse", resume, 1);
    chk("R5 halt released at resume", halt_o, 0);
    chk("R5 no request at resume", reqs(), 0);
    if (abort == 4) begin healthy_abort(healthy, bitn, "resume"); return; end
    @(negedge clk);
    chk("R5 resume one cycle", resume, 0);
    chk("R5 idle after resume", busy, 0);
    chk("R5 no fatal after recovery", fatal, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 halt after reset", halt_o, 0);
    chk("R1 requests after reset", reqs(), 0);
    chk("R1 resume after reset", resume, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 fatal after reset", fatal, 0);

    // full recoveries over every source of every core
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < NSRC; b++)
        do_rec(c, b, b % 3, 5);

    // healthy-core error at every stage
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 5; s++)
        do_rec(c, s % NSRC, 1, s);

    // simultaneous errors on both cores
    for (int i = 0; i < NSRC; i++)
      for (int j = 0; j < NSRC; j++) begin
        err_a = NSRC'(1) << i;
        err_b = NSRC'(1) << j;
        @(negedge clk);
        err_a = '0; err_b = '0;
        chk("R7 both cores -> fatal", fatal, 1);
        chk("R7 halt with fatal", halt_o, 1);
        @(negedge clk);
        chk("R8 fatal sticky after double error", fatal, 1);
        do_reset();
      end

    // back-to-back recovery after a clean one
    do_rec(1, 0, 0, 5);
    do_rec(0, NSRC - 1, 0, 5);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule